// File: doc/BRIEF.md
# Single-Pin GPIO and Edge-Interrupt Peripheral

This peripheral owns one bidirectional I/O pin and exposes it through four 32-bit word registers on a simple register bus. A configuration word selects how the pin is used. The pin can be a plain general-purpose line that floats as an input or is driven low or high. It can also be an edge-capture input, where chosen transitions latch a pending flag. An enable bit routes that flag to a single interrupt line. Software clears the flag by writing one to it.

The live pin level passes through a synchronizer. Software can always read that level from the status word, whatever the pin function. The bus writes one word per cycle when `bus_en` and `bus_we` are high. Read data is combinational from `bus_addr` while `bus_en` is high and `bus_we` is low.

Top module: `pin_edge_irq_unit`

## Requirements
- R1: After reset, the config word (offset 0x0) and the status flag read zero, `pin_oe` is 0 and `irq` is 0.
- R2: The config word at offset 0x0 reads back every one of its 32 bits exactly as last written. Offsets 0x4 and 0x8 always read zero, and writes to them change no register.
- R3: Config bits 5:4 control the pin driver. 00 and 01 leave `pin_oe` at 0. 10 gives `pin_oe`=1 with `pin_out`=0. 11 gives `pin_oe`=1 with `pin_out`=1.
- R4: Status bit 8 (offset 0xC) returns the pin level after a two-flop synchronizer, in every pin function. A pin change is visible there after the second rising clock edge.
- R5: When config bits 2:0 equal 1 (capture function), status bit 0 is set by the edges that config bits 17:16 select. 01 selects rising edges, 10 falling, 11 both and 00 none. The flag is set at the third rising clock edge after the pin changes.
- R6: When config bits 2:0 hold any value other than 1 (for example 4, plain GPIO), no pin edge sets status bit 0.
- R7: Writing a word with bit 0 set to offset 0xC clears status bit 0. Writing zero there leaves the flag unchanged. Status bits 7:1 and 31:9 read zero.
- R8: If a selected edge sets the flag in the same cycle as a clearing write, the flag stays set.
- R9: `irq` is a register loaded each cycle with the AND of status bit 0 and config bit 8. While bit 8 is clear, `irq` stays low but status bit 0 still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when not reading |
| pin_in | input | 1 | Pin level from the pad |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer and a four-bit address. That fixes the pin-to-flag latency at three edges and the flag-to-interrupt latency at one more. Directed cases can then land a clearing write in exactly the cycle that an edge reaches the flag logic. Random rounds cover every edge-select value, both pin functions and both enable states, and check the flag, the pin level and `irq` after each pin toggle.

// File: rtl/pin_edge_irq_unit.sv
module pin_edge_irq_unit #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              pin_in,
  output logic              pin_out,
  output logic              pin_oe,
  output logic              irq
);
  localparam logic [1:0] WORD_CFG  = 2'd0;
  localparam logic [1:0] WORD_STAT = 2'd3;
  localparam logic [2:0] FN_CAPTURE = 3'd1;

  logic [31:0]            cfg_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   level_d;
  logic                   flag_q;

  wire [1:0] word     = bus_addr[3:2];
  wire       wr_cfg   = bus_en && bus_we && word == WORD_CFG;
  wire       wr_clr   = bus_en && bus_we && word == WORD_STAT && bus_wdata[0];
  wire       level    = sync_q[SYNC_STAGES-1];
  wire       capture  = cfg_q[2:0] == FN_CAPTURE;
  wire       rise     = level && !level_d;
  wire       fall     = !level && level_d;
  wire       edge_hit = capture && ((rise && cfg_q[16]) || (fall && cfg_q[17]));

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
    end else begin : g_single
      always_ff @(posedge clk)
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      level_d <= 1'b0;
      flag_q  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata;
      level_d <= level;
      flag_q  <= edge_hit || (flag_q && !wr_clr);
      irq     <= flag_q && cfg_q[8];
    end
  end

  assign pin_oe  = cfg_q[5];
  assign pin_out = cfg_q[5] && cfg_q[4];

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we) begin
      if (word == WORD_CFG)       bus_rdata = cfg_q;
      else if (word == WORD_STAT) bus_rdata = {23'd0, level, 7'd0, flag_q};
    end
  end
endmodule

// File: rtl/pin_edge_irq_unit_chk.sv
module pin_edge_irq_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pin_out,
  input logic        pin_oe,
  input logic        irq,
  input logic [31:0] cfg_q,
  input logic        flag_q,
  input logic        edge_hit,
  input logic        wr_clr
);
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> flag_q);
  a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !edge_hit) |=> !flag_q);
  a_r6_no_flag_outside_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && cfg_q[2:0] != 3'd1) |=> !flag_q);
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(cfg_q[8]) && $past(flag_q));
  a_r3_out_only_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
    pin_out |-> pin_oe);
endmodule

bind pin_edge_irq_unit pin_edge_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .cfg_q(cfg_q), .flag_q(flag_q), .edge_hit(edge_hit), .wr_clr(wr_clr)
);

// File: tb/tb_pin_edge_irq_unit.sv
`timescale 1ns/1ps
module tb_pin_edge_irq_unit;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic pin_in = 0, pin_out, pin_oe, irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pin_edge_irq_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic bit exp_flag(input logic [31:0] cfg, input bit oldv, input bit newv);
    if (cfg[2:0] != 3'd1) return 0;
    if (!oldv && newv) return cfg[16];
    if (oldv && !newv) return cfg[17];
    return 0;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'h0, d); chk(d == 0, "R1 cfg", d, 0);
    rd(4'hC, d); chk(d == 0, "R1 status", d, 0);
    chk(pin_oe == 0 && irq == 0, "R1 oe/irq", {pin_oe, irq}, 0);
    // R2 readback and reserved
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, d); chk(d == 32'hFFFF_FFFF, "R2 readback", d, 32'hFFFF_FFFF);
    wr(4'h0, 32'hA5C3_0E40); rd(4'h0, d); chk(d == 32'hA5C3_0E40, "R2 readback2", d, 32'hA5C3_0E40);
    wr(4'h4, 32'h1234_5678); wr(4'h8, 32'h0000_0001);
    rd(4'h4, d); chk(d == 0, "R2 reserved4", d, 0);
    rd(4'h8, d); chk(d == 0, "R2 reserved8", d, 0);
    rd(4'h0, d); chk(d == 32'hA5C3_0E40, "R2 no side effect", d, 32'hA5C3_0E40);
    // R3 driver
    wr(4'h0, 32'h24); #1 chk(pin_oe == 1 && pin_out == 0, "R3 drive low", {pin_oe, pin_out}, 2'b10);
    wr(4'h0, 32'h34); #1 chk(pin_oe == 1 && pin_out == 1, "R3 drive high", {pin_oe, pin_out}, 2'b11);
    wr(4'h0, 32'h14); #1 chk(pin_oe == 0, "R3 01 input", pin_oe, 0);
    wr(4'h0, 32'h04); #1 chk(pin_oe == 0 && pin_out == 0, "R3 input", {pin_oe, pin_out}, 0);
    // R4 sync latency: visible after second edge
    @(negedge clk); pin_in = 1;
    @(posedge clk); #1 bus_en = 1; bus_addr = 4'hC;
    #0.5 chk(bus_rdata[8] == 0, "R4 one edge", bus_rdata[8], 0);
    @(posedge clk); #1 chk(bus_rdata[8] == 1, "R4 two edges", bus_rdata[8], 1);
    bus_en = 0;
    // R6 GPIO function does not flag edges
    wr(4'h0, 32'h0003_0104); @(negedge clk); pin_in = 0; settle();
    rd(4'hC, d); chk(d[0] == 0, "R6 gpio no flag", d, 0);
    chk(irq == 0, "R6 irq quiet", irq, 0);
    // R5 rise capture, R9 irq
    wr(4'h0, 32'h0001_0101); @(negedge clk); pin_in = 1; settle();
    rd(4'hC, d); chk(d == 32'h101, "R5 rise flag", d, 32'h101);
    chk(irq == 1, "R9 irq raised", irq, 1);
    // R7 zero write no effect, one clears
    wr(4'hC, 32'h0000_0000); rd(4'hC, d); chk(d[0] == 1, "R7 zero write", d, 1);
    wr(4'hC, 32'h0000_000F); rd(4'hC, d); chk(d[0] == 0, "R7 w1c", d, 0);
    @(negedge clk); chk(irq == 0, "R9 irq drops", irq, 0);
    // R9 masked still flags
    wr(4'h0, 32'h0002_0001); @(negedge clk); pin_in = 0; settle();
    rd(4'hC, d); chk(d[0] == 1, "R9 masked flag", d, 1);
    chk(irq == 0, "R9 masked irq", irq, 0);
    // R8 edge coincides with clear
    wr(4'h0, 32'h0003_0001);
    @(negedge clk); pin_in = 1;
    @(negedge clk); @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = 4'hC; bus_wdata = 32'h1;
    @(negedge clk); bus_en = 0; bus_we = 0;
    rd(4'hC, d); chk(d[0] == 1, "R8 set wins", d, 1);
    wr(4'hC, 32'h1);
    // random rounds: R5 R6 R9 R4
    for (int i = 0; i < 60; i++) begin
      logic [31:0] cfg;
      bit oldv, newv, ef;
      cfg = {14'd0, 2'($urandom), 7'd0, 1'($urandom), 5'd0, ($urandom % 3 == 0) ? 3'd4 : 3'd1};
      wr(4'h0, cfg); wr(4'hC, 32'h1);
      oldv = pin_in; newv = 1'($urandom);
      @(negedge clk); pin_in = newv; settle();
      ef = exp_flag(cfg, oldv, newv);
      rd(4'hC, d);
      chk(d[0] == ef, "R5 random flag", d[0], ef);
      chk(d[8] == newv, "R4 random level", d[8], newv);
      chk(irq == (ef && cfg[8]), "R9 random irq", irq, ef && cfg[8]);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule